// File: doc/BRIEF.md
# Contrast Stretch Table and Pixel Remapper

This block turns a pair of input intensity bounds into a 256-entry stretch curve and then plays a stored frame through that curve. When a start pulse arrives, the block latches a low bound and a high bound. It then spends one clock cycle on each table entry and writes a piecewise-linear mapping. The span from black up to the low bound is squeezed onto 0..25. The span between the bounds is spread across 25..229. The span from the high bound up to white is squeezed onto 229..255.

When the last entry has been written, the block asks an external frame store for the frame with a single-cycle fetch request. Each valid pixel that comes back is used as a table address, and the stretched value leaves one cycle later. The valid flag and the start-of-frame and end-of-frame flags are delayed by the same cycle. The pixel that carries end-of-frame closes the replay. A new start pulse may arrive in that same cycle, so that the next curve is built straight after the frame. The bounds come from an external source, and the frame store lies outside this block.

Top module: `stretch_remap`

## Requirements
- R1: While reset is held and in the first cycle after it is released, map_valid, map_sof, map_eof and fetch_req are all 0.
- R2: A start pulse is accepted when the block is idle, or when it is replaying and the same cycle carries a valid pixel with pix_eof. An accepted start latches bound_lo and bound_hi. A start pulse at any other time, including during the table build, is ignored and leaves the curve unchanged.
- R3: fetch_req is high for exactly one cycle. It goes high 256 cycles after the cycle in which start was sampled, because the table is written one entry per cycle.
- R4: When bound_hi > bound_lo, an entry i with i < bound_lo holds floor(i*25/bound_lo).
- R5: When bound_hi > bound_lo, an entry i with bound_lo <= i <= bound_hi holds 25 + floor((i-bound_lo)*204/(bound_hi-bound_lo)). Over the whole table the curve never decreases.
- R6: When bound_hi > bound_lo, an entry i with i > bound_hi holds 229 + floor((i-bound_hi)*26/(255-bound_hi)).
- R7: When bound_hi <= bound_lo, an entry i with i <= bound_lo holds 25, and every other entry holds 229.
- R8: During replay, each pixel with pix_valid=1 gives map_valid=1 on the next cycle. map_pix then holds the table entry addressed by pix_in, and map_sof and map_eof repeat pix_sof and pix_eof.
- R9: A pixel that arrives when the block is not replaying is dropped: map_valid stays 0 on the following cycle.
- R10: Replay ends after the pixel that carries pix_eof. That pixel is mapped through the curve in force before any start accepted in the same cycle. The new curve is then built, and a new fetch_req follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to build a new curve |
| bound_lo | input | 8 | Low input intensity bound |
| bound_hi | input | 8 | High input intensity bound |
| fetch_req | output | 1 | One-cycle request for the stored frame |
| pix_valid | input | 1 | Pixel from the frame store is valid |
| pix_sof | input | 1 | First pixel of the frame |
| pix_eof | input | 1 | Last pixel of the frame |
| pix_in | input | 8 | Stored pixel intensity |
| map_valid | output | 1 | Stretched pixel is valid |
| map_sof | output | 1 | Delayed start-of-frame flag |
| map_eof | output | 1 | Delayed end-of-frame flag |
| map_pix | output | 8 | Stretched intensity |

## Verification
The table lookup for the final pixel of a frame and the acceptance of a new build request can happen in the same cycle. The bench provokes this by raising start, with new bounds, together with the pixel that carries end-of-frame. It then expects that pixel to come out mapped through the old curve. It also expects the fetch request to return after the full build time. A later frame must be mapped through the new curve.

// File: rtl/stretch_remap.sv
module stretch_remap #(
  parameter int PIX_W   = 8,
  parameter int LO_PCT  = 10,
  parameter int HI_PCT  = 90
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PIX_W-1:0] bound_lo,
  input  logic [PIX_W-1:0] bound_hi,
  output logic             fetch_req,
  input  logic             pix_valid,
  input  logic             pix_sof,
  input  logic             pix_eof,
  input  logic [PIX_W-1:0] pix_in,
  output logic             map_valid,
  output logic             map_sof,
  output logic             map_eof,
  output logic [PIX_W-1:0] map_pix
);

  localparam int DEPTH = 1 << PIX_W;
  localparam int PMAX  = DEPTH - 1;
  localparam int W2    = 2 * PIX_W;
  localparam logic [PIX_W-1:0] A_LO = PIX_W'((LO_PCT * PMAX) / 100);
  localparam logic [PIX_W-1:0] A_HI = PIX_W'((HI_PCT * PMAX) / 100);
  localparam logic [PIX_W-1:0] TOP  = PIX_W'(PMAX);

  typedef enum logic [1:0] {S_IDLE, S_BUILD, S_REQ, S_STREAM} st_t;

  st_t              state;
  logic [PIX_W-1:0] idx, lo_r, hi_r, wr_val;
  logic [PIX_W-1:0] tbl [DEPTH];
  logic [W2-1:0]    num, den, base, quo;
  logic             take_start, accept, last_pix;

  assign fetch_req  = (state == S_REQ);
  assign accept     = (state == S_STREAM) && pix_valid;
  assign last_pix   = accept && pix_eof;
  assign take_start = start && ((state == S_IDLE) || last_pix);

  // one shared divider: pick the segment, then base + num/den
  always_comb begin
    num  = '0;
    den  = W2'(1);
    base = '0;
    if (hi_r <= lo_r) begin
      base = (idx <= lo_r) ? W2'(A_LO) : W2'(A_HI);
    end else if (idx < lo_r) begin
      num  = W2'(idx) * W2'(A_LO);
      den  = W2'(lo_r);
    end else if (idx <= hi_r) begin
      num  = (W2'(idx) - W2'(lo_r)) * (W2'(A_HI) - W2'(A_LO));
      den  = W2'(hi_r) - W2'(lo_r);
      base = W2'(A_LO);
    end else begin
      num  = (W2'(idx) - W2'(hi_r)) * (W2'(TOP) - W2'(A_HI));
      den  = W2'(TOP) - W2'(hi_r);
      base = W2'(A_HI);
    end
    quo    = num / den;
    wr_val = PIX_W'(base + quo);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      lo_r  <= '0;
      hi_r  <= '0;
    end else begin
      if (take_start) begin
        lo_r <= bound_lo;
        hi_r <= bound_hi;
        idx  <= '0;
      end
      case (state)
        S_IDLE:   if (take_start) state <= S_BUILD;
        S_BUILD: begin
          idx <= idx + 1'b1;
          if (idx == TOP) state <= S_REQ;
        end
        S_REQ:    state <= S_STREAM;
        S_STREAM: if (last_pix) state <= take_start ? S_BUILD : S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_BUILD) tbl[idx] <= wr_val;
    if (accept) map_pix <= tbl[pix_in];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_valid <= 1'b0;
      map_sof   <= 1'b0;
      map_eof   <= 1'b0;
    end else begin
      map_valid <= accept;
      map_sof   <= accept && pix_sof;
      map_eof   <= accept && pix_eof;
    end
  end

  // R3
  fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> !fetch_req);

  // R8
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid |-> $past(pix_valid));

  // R8
  sof_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_sof || map_eof) |-> map_valid);

  // R9
  build_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUILD && $past(state) == S_BUILD) |-> !map_valid);

  // R5
  lo_anchor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUILD && hi_r > lo_r && idx == lo_r) |-> wr_val == A_LO);

  // R5
  hi_anchor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUILD && hi_r > lo_r && idx == hi_r) |-> wr_val == A_HI);

  // R5
  monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUILD && idx != '0) |-> wr_val >= $past(wr_val));

  // R7
  flat_curve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUILD && hi_r <= lo_r) |-> (wr_val == A_LO || wr_val == A_HI));

endmodule

// File: tb/stretch_remap_bench.sv
module stretch_remap_bench;
  logic       clk = 1'b0;
  logic       rst_n, start, pix_valid, pix_sof, pix_eof;
  logic [7:0] bound_lo, bound_hi, pix_in, map_pix;
  logic       fetch_req, map_valid, map_sof, map_eof;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  stretch_remap u_stretch_remap (
    .clk(clk), .rst_n(rst_n), .start(start), .bound_lo(bound_lo), .bound_hi(bound_hi),
    .fetch_req(fetch_req), .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_eof(pix_eof),
    .pix_in(pix_in), .map_valid(map_valid), .map_sof(map_sof), .map_eof(map_eof),
    .map_pix(map_pix)
  );

  // {lo, hi, pix, expected}
  localparam int NV = 21;
  localparam logic [31:0] VEC [NV] = '{
    {8'd50, 8'd200, 8'd0,   8'd0},   {8'd50, 8'd200, 8'd10,  8'd5},
    {8'd50, 8'd200, 8'd49,  8'd24},  {8'd50, 8'd200, 8'd50,  8'd25},
    {8'd50, 8'd200, 8'd125, 8'd127}, {8'd50, 8'd200, 8'd199, 8'd227},
    {8'd50, 8'd200, 8'd200, 8'd229}, {8'd50, 8'd200, 8'd201, 8'd229},
    {8'd50, 8'd200, 8'd230, 8'd243}, {8'd50, 8'd200, 8'd255, 8'd255},
    {8'd0,  8'd255, 8'd0,   8'd25},  {8'd0,  8'd255, 8'd1,   8'd25},
    {8'd0,  8'd255, 8'd128, 8'd127}, {8'd0,  8'd255, 8'd255, 8'd229},
    {8'd100,8'd100, 8'd0,   8'd25},  {8'd100,8'd100, 8'd100, 8'd25},
    {8'd100,8'd100, 8'd101, 8'd229}, {8'd100,8'd100, 8'd255, 8'd229},
    {8'd120,8'd60,  8'd60,  8'd25},  {8'd120,8'd60,  8'd120, 8'd25},
    {8'd120,8'd60,  8'd121, 8'd229}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called one negedge after start was sampled; start was applied one edge earlier
  task automatic wait_fetch(input string tag);
    int n = 1;
    while (!fetch_req && n < 600) begin
      @(negedge clk);
      n++;
    end
    chk(tag, n, 257);
    @(negedge clk);
    chk(tag, fetch_req, 0);
  endtask

  task automatic run_build(input logic [7:0] lo, input logic [7:0] hi, input string tag);
    start = 1'b1; bound_lo = lo; bound_hi = hi;
    @(negedge clk);
    start = 1'b0;
    wait_fetch(tag);
  endtask

  task automatic send_one(input logic [7:0] p, input int exp, input string tag);
    pix_valid = 1'b1; pix_in = p; pix_sof = 1'b1; pix_eof = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eof = 1'b0;
    chk(tag, map_valid, 1);
    chk(tag, map_pix, exp);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; bound_lo = '0; bound_hi = '0;
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eof = 1'b0; pix_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", map_valid, 0);
    chk("R1 reset fetch", fetch_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset flags", {map_valid, map_sof, map_eof, fetch_req}, 0);

    // R9: pixel while idle is dropped
    pix_valid = 1'b1; pix_in = 8'd77; pix_sof = 1'b1; pix_eof = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eof = 1'b0;
    chk("R9 idle drop", map_valid, 0);

    // curve table walked as back-to-back frames, one frame per bound pair
    for (int i = 0; i < NV; i++) begin
      bit first, last;
      string tag;
      logic [7:0] lo, hi, p, e;
      {lo, hi, p, e} = VEC[i];
      first = (i == 0) ? 1'b1 : (VEC[i][31:16] != VEC[(i == 0) ? 0 : i-1][31:16]);
      last  = (i == NV-1) ? 1'b1 : (VEC[i][31:16] != VEC[(i == NV-1) ? i : i+1][31:16]);
      if (first) run_build(lo, hi, "R3 fetch timing");
      if (hi <= lo)     tag = "R7 flat curve";
      else if (p < lo)  tag = "R4 lower segment";
      else if (p <= hi) tag = "R5 middle segment";
      else              tag = "R6 upper segment";
      pix_valid = 1'b1; pix_in = p; pix_sof = first; pix_eof = last;
      @(negedge clk);
      pix_valid = 1'b0;
      chk(tag, map_pix, e);
      chk("R8 valid", map_valid, 1);
      chk("R8 sof", map_sof, first);
      chk("R8 eof", map_eof, last);
    end

    // R10: after the end-of-frame pixel the replay is closed
    pix_valid = 1'b1; pix_in = 8'd30; pix_sof = 1'b1; pix_eof = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eof = 1'b0;
    chk("R10 closed after eof", map_valid, 0);

    // R2: start during build ignored; R9: pixel during build dropped
    start = 1'b1; bound_lo = 8'd50; bound_hi = 8'd200;
    @(negedge clk);
    start = 1'b0;
    begin
      int n = 1;
      repeat (10) begin @(negedge clk); n++; end
      start = 1'b1; bound_lo = 8'd0; bound_hi = 8'd255;
      pix_valid = 1'b1; pix_in = 8'd10;
      @(negedge clk); n++;
      start = 1'b0; pix_valid = 1'b0;
      chk("R9 build drop", map_valid, 0);
      while (!fetch_req && n < 600) begin @(negedge clk); n++; end
      chk("R2 late start ignored, fetch timing", n, 257);
      @(negedge clk);
    end
    send_one(8'd10, 5, "R2 curve unchanged");

    // R10: start coincides with the final pixel of a frame
    run_build(8'd50, 8'd200, "R3 fetch timing");
    pix_valid = 1'b1; pix_in = 8'd125; pix_sof = 1'b1; pix_eof = 1'b0;
    @(negedge clk);
    chk("R10 first pixel", map_pix, 127);
    pix_in = 8'd10; pix_sof = 1'b0; pix_eof = 1'b1;
    start = 1'b1; bound_lo = 8'd0; bound_hi = 8'd255;
    @(negedge clk);
    start = 1'b0; pix_valid = 1'b0; pix_eof = 1'b0;
    chk("R10 last pixel old curve", map_pix, 5);
    chk("R10 last pixel eof", map_eof, 1);
    wait_fetch("R10 rebuild fetch");
    send_one(8'd10, 33, "R10 new curve applied");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule